// File: doc/BRIEF.md
# Edge-Triggered One-Shot Pulse Timer

This block measures a programmable delay that starts on an edge of an external trigger pin. It stays idle until the chosen edge of the trigger arrives. It then counts ticks of a prescaled internal clock in a 16-bit up-counter, and compares the count with a compare value. When the count reaches that value, the block raises a one-cycle interrupt, clears the counter and halts. Only a new trigger edge starts it again.

A width-check option turns the block into a detector for a minimum pulse width. With the option on, the opposite edge aborts a count that is in progress, and no interrupt is raised. The interrupt then fires only for trigger pulses that last at least the compare time.

Before edge detection, the trigger passes through a two-flop synchronizer and a glitch filter. The filter changes its output level only after the synchronized input has held the new level for `FILT_THRESH` consecutive clocks (8 by default). A bypass input skips the filter when the block runs in a low-power mode.

Top module: `edge_oneshot_timer`

## Requirements
- R1: After reset `irq` is 0 and the timer is idle. While idle, no interrupt is produced until a selected trigger edge arrives.
- R2: `edge_fall`=0 selects rising trigger edges as the start event. `edge_fall`=1 selects falling edges. The selected edge starts counting from zero.
- R3: `psc_sel` value s sets a tick period of D = 8^s clocks (1, 8, 64 or 512). With the filter in use, `irq` is high on the (FILT_THRESH + 3 + N*D)-th rising clock edge after the trigger pin changes, where N = `cmp_val`. The pulse lasts exactly one clock.
- R4: On a match the counter is cleared and the timer halts. The next selected edge restarts it with the same latency as the first start.
- R5: Selected-polarity edges that arrive while counting are ignored. They neither restart nor extend the count.
- R6: With `width_mode`=0, opposite-polarity edges have no effect on a count in progress.
- R7: With `width_mode`=1, an opposite-polarity edge during counting clears and stops the counter with no interrupt. A pulse held long enough still gives the interrupt at the R3 latency.
- R8: With `filt_bypass`=0, a trigger pulse shorter than FILT_THRESH clocks is rejected. A pulse of FILT_THRESH clocks or more is accepted: 4-clock and 7-clock pulses are dropped, while 8-clock and 12-clock pulses are seen.
- R9: With `filt_bypass`=1, the filter is skipped and a one-clock trigger pulse is seen. The latency is then 4 + N*D rising edges.
- R10: While `run_en` is 0, the counter is held at zero and the timer is idle. Dropping `run_en` during a count cancels it with no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_raw | input | 1 | Raw external trigger pin |
| edge_fall | input | 1 | Start polarity: 0 rising, 1 falling |
| width_mode | input | 1 | 1 = an opposite edge aborts the count |
| psc_sel | input | 2 | Prescaler select: tick every 8^psc_sel clocks |
| cmp_val | input | 16 | Compare value, in ticks |
| run_en | input | 1 | Start enable; 0 forces idle and clears the count |
| filt_bypass | input | 1 | 1 = skip the glitch filter (low-power operation) |
| irq | output | 1 | One-cycle interrupt on a compare match |

## Verification
The bench measures exact interrupt latency in clocks. This would expose an off-by-one at the compare, a prescaler that free-runs instead of restarting from a clean phase, or a miscounted stage in the trigger path. It re-triggers and reverses the pin during a count: a design that restarts on repeated edges gives a late interrupt, and one that ignores the width option gives an interrupt that should have been suppressed. It sends pulses just below and just at the filter threshold, and one-clock pulses with the filter bypassed, so that an off-by-one in the filter counter drops or passes the wrong pulse. It also drops the start enable during a count, which catches a design that keeps counting and fires anyway.

// File: rtl/eot_pkg.sv
package eot_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } run_state_t;

   // each prescaler setting divides by 2**PSC_STEP more than the previous one
   localparam int PSC_STEP = 3;

   function automatic int psc_cnt_width(input int sel_w, input int step);
      return step * ((1 << sel_w) - 1);
   endfunction

endpackage

// File: rtl/eot_trig_filter.sv
module eot_trig_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_THRESH = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_in,
   input  logic bypass,
   output logic sync_o,
   output logic filt_o
);
   localparam int FC_W = $clog2(FILT_THRESH);

   logic [SYNC_STAGES-1:0] sync_sr;
   logic [FC_W-1:0]        stab_cnt;
   logic                   filt_q;

   // synchronizer chain, one flop per stage
   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_sr[0] <= 1'b0;
            else        sync_sr[0] <= raw_in;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_sr[g] <= 1'b0;
            else        sync_sr[g] <= sync_sr[g-1];
      end
   end

   assign sync_o = sync_sr[SYNC_STAGES-1];

   // saturating stability counter: level moves after FILT_THRESH differing samples
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_q   <= 1'b0;
         stab_cnt <= '0;
      end else if (bypass) begin
         filt_q   <= sync_o;
         stab_cnt <= '0;
      end else if (sync_o != filt_q) begin
         if (stab_cnt == FC_W'(FILT_THRESH - 1)) begin
            filt_q   <= sync_o;
            stab_cnt <= '0;
         end else begin
            stab_cnt <= stab_cnt + FC_W'(1);
         end
      end else begin
         stab_cnt <= '0;
      end
   end

   assign filt_o = filt_q;

endmodule

// File: rtl/eot_edge_sel.sv
module eot_edge_sel (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   input  logic fall_sel,
   output logic sel_edge_o,
   output logic opp_edge_o
);
   logic lvl_d;
   logic rise_ev;
   logic fall_ev;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) lvl_d <= 1'b0;
      else        lvl_d <= lvl_i;

   assign rise_ev    = lvl_i & ~lvl_d;
   assign fall_ev    = ~lvl_i & lvl_d;
   assign sel_edge_o = fall_sel ? fall_ev : rise_ev;
   assign opp_edge_o = fall_sel ? rise_ev : fall_ev;

endmodule

// File: rtl/eot_prescaler.sv
module eot_prescaler #(
   parameter int SEL_W = 2,
   parameter int STEP  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [SEL_W-1:0] sel,
   output logic             tick_o
);
   localparam int PW = STEP * ((1 << SEL_W) - 1);

   logic [PW-1:0] pcnt;
   logic [PW-1:0] mask;

   // low STEP*sel bits participate in the tick compare
   for (genvar b = 0; b < PW; b++) begin : g_mask
      assign mask[b] = (int'(sel) * STEP) > b;
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)     pcnt <= '0;
      else if (clear) pcnt <= '0;
      else            pcnt <= pcnt + PW'(1);

   assign tick_o = ((pcnt & mask) == mask);

endmodule

// File: rtl/eot_count_core.sv
module eot_count_core
   import eot_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             width_mode,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             sel_edge,
   input  logic             opp_edge,
   input  logic             tick,
   output logic             irq_o,
   output logic             running_o,
   output logic [CNT_W-1:0] cnt_o
);
   run_state_t       state;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_inc;
   logic             irq_q;

   assign cnt_inc = cnt + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         irq_q <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (!run_en) begin
            state <= ST_IDLE;
            cnt   <= '0;
         end else if (state == ST_IDLE) begin
            if (sel_edge) begin
               state <= ST_RUN;
               cnt   <= '0;
            end
         end else begin
            if (width_mode && opp_edge) begin
               state <= ST_IDLE;
               cnt   <= '0;
            end else if (tick) begin
               if (cnt_inc == cmp_val) begin
                  irq_q <= 1'b1;
                  state <= ST_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt_inc;
               end
            end
         end
      end
   end

   assign irq_o     = irq_q;
   assign running_o = (state == ST_RUN);
   assign cnt_o     = cnt;

endmodule

// File: rtl/edge_oneshot_timer.sv
module edge_oneshot_timer
   import eot_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PSC_SEL_W   = 2,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_THRESH = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 trig_raw,
   input  logic                 edge_fall,
   input  logic                 width_mode,
   input  logic [PSC_SEL_W-1:0] psc_sel,
   input  logic [CNT_W-1:0]     cmp_val,
   input  logic                 run_en,
   input  logic                 filt_bypass,
   output logic                 irq
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("edge_oneshot_timer: CNT_W must be at least 2");
   end
   if (PSC_SEL_W < 1) begin : g_bad_psc
      $error("edge_oneshot_timer: PSC_SEL_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("edge_oneshot_timer: SYNC_STAGES must be at least 2");
   end
   if (FILT_THRESH < 2 || FILT_THRESH > 255) begin : g_bad_filt
      $error("edge_oneshot_timer: FILT_THRESH must lie in 2..255");
   end

   logic             sync_lvl;
   logic             filt_lvl;
   logic             sel_edge;
   logic             opp_edge;
   logic             psc_tick;
   logic             run_q;
   logic [CNT_W-1:0] cnt_q;

   eot_trig_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .FILT_THRESH (FILT_THRESH)
   ) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_in (trig_raw),
      .bypass (filt_bypass),
      .sync_o (sync_lvl),
      .filt_o (filt_lvl)
   );

   eot_edge_sel u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl_i      (filt_lvl),
      .fall_sel   (edge_fall),
      .sel_edge_o (sel_edge),
      .opp_edge_o (opp_edge)
   );

   eot_prescaler #(
      .SEL_W (PSC_SEL_W),
      .STEP  (PSC_STEP)
   ) u_psc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (~run_q),
      .sel    (psc_sel),
      .tick_o (psc_tick)
   );

   eot_count_core #(
      .CNT_W (CNT_W)
   ) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_en     (run_en),
      .width_mode (width_mode),
      .cmp_val    (cmp_val),
      .sel_edge   (sel_edge),
      .opp_edge   (opp_edge),
      .tick       (psc_tick),
      .irq_o      (irq),
      .running_o  (run_q),
      .cnt_o      (cnt_q)
   );

endmodule

// File: rtl/eot_checker.sv
module eot_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_en,
   input logic             width_mode,
   input logic             filt_bypass,
   input logic             irq,
   input logic             running,
   input logic [CNT_W-1:0] cnt,
   input logic             sel_edge,
   input logic             opp_edge,
   input logic             tick,
   input logic             sync_lvl,
   input logic             filt_lvl
);

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      run_en && !running && !sel_edge |=> !running); // R1

   AST_EDGE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      run_en && !running && sel_edge |=> running && cnt == '0); // R2

   AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq); // R3

   AST_HALT_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !running && cnt == '0); // R4

   AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
      run_en && running && sel_edge && !tick |=> running && cnt == $past(cnt)); // R5

   AST_OPP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      run_en && running && !width_mode && opp_edge && !tick |=> running); // R6

   AST_WIDTH_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      run_en && running && width_mode && opp_edge |=> !running && !irq); // R7

   AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !filt_bypass && (sync_lvl == filt_lvl) |=> $stable(filt_lvl)); // R8

   AST_FILT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      filt_bypass |=> filt_lvl == $past(sync_lvl)); // R9

   AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> !irq && !running && cnt == '0); // R10

endmodule

bind edge_oneshot_timer eot_checker #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .run_en      (run_en),
   .width_mode  (width_mode),
   .filt_bypass (filt_bypass),
   .irq         (irq),
   .running     (run_q),
   .cnt         (cnt_q),
   .sel_edge    (sel_edge),
   .opp_edge    (opp_edge),
   .tick        (psc_tick),
   .sync_lvl    (sync_lvl),
   .filt_lvl    (filt_lvl)
);

// File: tb/edge_oneshot_timer_tb.sv
`timescale 1ns/1ps
module edge_oneshot_timer_tb;

   localparam int THR = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trig_raw = 1'b0;
   logic        edge_fall = 1'b0;
   logic        width_mode = 1'b0;
   logic [1:0]  psc_sel = 2'd1;
   logic [15:0] cmp_val = 16'd5;
   logic        run_en = 1'b1;
   logic        filt_bypass = 1'b0;
   logic        irq;

   int    checks = 0;
   int    errors = 0;
   int    cycles = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   edge_oneshot_timer u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .trig_raw    (trig_raw),
      .edge_fall   (edge_fall),
      .width_mode  (width_mode),
      .psc_sel     (psc_sel),
      .cmp_val     (cmp_val),
      .run_en      (run_en),
      .filt_bypass (filt_bypass),
      .irq         (irq)
   );

   // behavioural reference, advanced once per rising edge
   bit m_s1, m_s2, m_filt, m_filtd, m_run, m_irq;
   int m_fc, m_cnt, m_pc;

   always @(posedge clk) begin
      bit e_r, e_f, sel, opp, tk;
      int div, new_pc;
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_filt = 0; m_filtd = 0; m_run = 0; m_irq = 0;
         m_fc = 0; m_cnt = 0; m_pc = 0;
      end else begin
         e_r = m_filt && !m_filtd;
         e_f = !m_filt && m_filtd;
         sel = edge_fall ? e_f : e_r;
         opp = edge_fall ? e_r : e_f;
         div = 1 << (3 * int'(psc_sel));
         tk  = ((m_pc % div) == div - 1);
         new_pc = m_run ? (m_pc + 1) % 512 : 0;
         m_irq = 0;
         if (!run_en) begin
            m_run = 0; m_cnt = 0;
         end else if (!m_run) begin
            if (sel) begin m_run = 1; m_cnt = 0; end
         end else if (width_mode && opp) begin
            m_run = 0; m_cnt = 0;
         end else if (tk) begin
            if (((m_cnt + 1) % 65536) == int'(cmp_val)) begin
               m_irq = 1; m_run = 0; m_cnt = 0;
            end else begin
               m_cnt = m_cnt + 1;
            end
         end
         m_pc = new_pc;
         m_filtd = m_filt;
         if (filt_bypass) begin
            m_filt = m_s2; m_fc = 0;
         end else if (m_s2 != m_filt) begin
            if (m_fc == THR - 1) begin m_filt = m_s2; m_fc = 0; end
            else m_fc = m_fc + 1;
         end else begin
            m_fc = 0;
         end
         m_s2 = m_s1;
         m_s1 = trig_raw;
      end
   end

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      cycles++;
      if (rst_n && !done) begin
         checks++;
         if (irq !== m_irq) begin
            errors++;
            $display("FAIL %s: irq actual %0b expected %0b at cycle %0d", cur_req, irq, m_irq, cycles);
         end
      end
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic watch(input int n, inout int k, inout int first, inout int cnt);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         k++;
         if (irq) begin
            cnt++;
            if (first < 0) first = k;
         end
      end
   endtask

   task automatic idle_wait(input int n);
      int k = 0, f = -1, c = 0;
      watch(n, k, f, c);
   endtask

   // change the pin, then watch; expect first irq at exp_k (or none if exp_k<0)
   task automatic pin_then(input string req, input bit lvl, input int win, input int exp_k);
      int k = 0, f = -1, c = 0;
      @(negedge clk);
      trig_raw = lvl;
      watch(win, k, f, c);
      check(req, f, exp_k);
      check(req, c, (exp_k < 0) ? 0 : 1);
   endtask

   task automatic pulse_then(input string req, input int width, input int win, input int exp_k);
      int k = 0, f = -1, c = 0;
      @(negedge clk);
      trig_raw = 1'b1;
      watch(width, k, f, c);
      trig_raw = 1'b0;
      watch(win, k, f, c);
      check(req, f, exp_k);
      check(req, c, (exp_k < 0) ? 0 : 1);
   endtask

   initial begin
      int k, f, c;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state and quiet idle
      cur_req = "R1";
      check("R1", int'(irq), 0);
      pin_then("R1", 1'b0, 30, -1);

      // R2 / R3: rising start, latency THR+3+5*8 = 51
      cur_req = "R3";
      pin_then("R3", 1'b1, 120, 51);

      // R4: restart after match-halt gives the same latency
      cur_req = "R4";
      pin_then("R4", 1'b0, 30, -1);
      pin_then("R4", 1'b1, 120, 51);

      // R5: re-trigger during count ignored
      cur_req = "R5";
      pin_then("R5", 1'b0, 30, -1);
      k = 0; f = -1; c = 0;
      @(negedge clk); trig_raw = 1'b1;
      watch(20, k, f, c);
      trig_raw = 1'b0;
      watch(15, k, f, c);
      trig_raw = 1'b1;
      watch(85, k, f, c);
      check("R5", f, 51);
      check("R5", c, 1);

      // R6: opposite edge ignored with width_mode=0
      cur_req = "R6";
      pin_then("R6", 1'b0, 30, -1);
      pulse_then("R6", 20, 100, 51);

      // R7: opposite edge aborts with width_mode=1
      cur_req = "R7";
      width_mode = 1'b1;
      pulse_then("R7", 20, 200, -1);
      pin_then("R7", 1'b1, 120, 51);
      pin_then("R7", 1'b0, 30, -1);
      width_mode = 1'b0;

      // R2: falling polarity
      cur_req = "R2";
      run_en = 1'b0;
      pin_then("R2", 1'b1, 30, -1);
      edge_fall = 1'b1;
      run_en = 1'b1;
      idle_wait(5);
      pin_then("R2", 1'b0, 120, 51);
      edge_fall = 1'b0;
      idle_wait(5);

      // R8: glitch filter threshold
      cur_req = "R8";
      pulse_then("R8", 4, 150, -1);
      pulse_then("R8", 7, 150, -1);
      pulse_then("R8", 8, 112, 51);
      pulse_then("R8", 12, 108, 51);

      // R9: bypass passes a one-clock pulse, latency 4+40
      cur_req = "R9";
      filt_bypass = 1'b1;
      idle_wait(5);
      pulse_then("R9", 1, 100, 44);
      filt_bypass = 1'b0;
      idle_wait(10);

      // R10: dropping run_en cancels the count
      cur_req = "R10";
      k = 0; f = -1; c = 0;
      @(negedge clk); trig_raw = 1'b1;
      watch(20, k, f, c);
      run_en = 1'b0;
      watch(3, k, f, c);
      run_en = 1'b1;
      watch(200, k, f, c);
      check("R10", c, 0);
      pin_then("R10", 1'b0, 30, -1);
      pin_then("R10", 1'b1, 120, 51);
      pin_then("R10", 1'b0, 30, -1);

      // R3: other prescaler settings
      cur_req = "R3";
      psc_sel = 2'd0; cmp_val = 16'd3;
      pin_then("R3", 1'b1, 60, 14);
      pin_then("R3", 1'b0, 30, -1);
      psc_sel = 2'd2; cmp_val = 16'd2;
      pin_then("R3", 1'b1, 200, 139);
      pin_then("R3", 1'b0, 30, -1);
      psc_sel = 2'd3; cmp_val = 16'd1;
      pin_then("R3", 1'b1, 600, 523);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule